// File: doc/BRIEF.md
# Prioritised Fast/Normal Interrupt Controller

The block gathers 64 level-sensitive interrupt lines and drives the two interrupt inputs of a processor: a fast line and a normal line. Each source is switched on or off on its own and, when on, is routed to either the fast or the normal line. Both lines are level outputs. A line is high while any enabled source routed to it is high.

For each line, a combinational priority resolver picks the highest-ranked pending source. A status word returns that source's number, so the handler can branch to it without scanning the pending bits. Sources 0 to 7 each carry a programmable 3-bit priority slot. Sources 8 to 31 follow a fixed order in which the lower number wins. Sources 32 to 63 normally rank below all of sources 0 to 31. A single control bit promotes sources 32 to 63 above every source in 0 to 31.

A word-addressed register port with a single write strobe and a combinational read path holds the configuration and returns the status.

Top module: `prio_intc`

## Requirements
- R1: After reset, every source is disabled and routed to the normal line, all slots are 0, and the promote bit is 0. Both lines are low and every register reads 0.
- R2: A source whose enable bit is 0 never raises either line and is never reported as a winner. Enable bits sit at address 0 (sources 0-31) and address 1 (sources 32-63), with bit n for source 32*word+n.
- R3: The route bits at address 2 (sources 0-31) and address 3 (sources 32-63) send source n to the fast line when set and to the normal line when clear. The two lines are resolved independently.
- R4: `fiq_o` is high exactly when some source is high, enabled and routed fast. `irq_o` is high exactly when some source is high, enabled and routed normal. Both follow `src_i` in the same cycle.
- R5: Sources 0-7 rank above all other sources when promotion is off. Among them the larger slot value wins. The slot for source p sits in bits [3p+2:3p] of address 4.
- R6: Among sources 0-7 that hold equal slot values, the lower source number wins.
- R7: Sources 8-31 rank in ascending number order. With promotion off, sources 32-63 rank below source 31, also in ascending number order.
- R8: When bit 0 of address 5 is set, any pending source in 32-63 outranks every source in 0-31, including sources 0-7.
- R9: Address 8 returns the fast-line winner and address 9 the normal-line winner. Bit 31 is the valid flag and bits [5:0] hold the source number. When nothing is pending, the whole word is 0.
- R10: Addresses 0-5 read back what was last written to them. Addresses 6 and 7 return the raw `src_i` levels for sources 0-31 and 32-63. Writes to addresses 6 to 9 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| src_i | input | 64 | Level-sensitive interrupt sources, synchronous to clk_i |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 4 | Register word address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, combinational from reg_addr_i |
| fiq_o | output | 1 | Fast interrupt request |
| irq_o | output | 1 | Normal interrupt request |

## Verification
The assertions assume that `src_i` and the register inputs are synchronous to the clock and hold no X values once reset is released. The configuration-hold checks assume that a register changes only in a cycle when the write strobe is high. The bench drives every input only at the falling edge and keeps the write strobe high for exactly one rising edge per access. It holds `src_i` steady across each comparison, so that the combinational outputs and reads are sampled after they have settled.

// File: rtl/intc_pkg.sv
package intc_pkg;
  localparam int ADDR_W = 4;
  localparam logic [ADDR_W-1:0] A_EN    = 4'd0;  // two words
  localparam logic [ADDR_W-1:0] A_ROUTE = 4'd2;  // two words, 1 = fast
  localparam logic [ADDR_W-1:0] A_SLOT  = 4'd4;
  localparam logic [ADDR_W-1:0] A_CTRL  = 4'd5;
  localparam logic [ADDR_W-1:0] A_RAW   = 4'd6;  // two words
  localparam logic [ADDR_W-1:0] A_FWIN  = 4'd8;
  localparam logic [ADDR_W-1:0] A_NWIN  = 4'd9;

  // rank tiers, larger wins
  localparam logic [1:0] T_UPPER_LOW = 2'd0;
  localparam logic [1:0] T_FIXED     = 2'd1;
  localparam logic [1:0] T_PROG      = 2'd2;
  localparam logic [1:0] T_UPPER_HI  = 2'd3;
endpackage

// File: rtl/intc_regs.sv
module intc_regs
  import intc_pkg::*;
#(
  parameter int N_SRC  = 64,
  parameter int N_PROG = 8,
  parameter int SLOT_W = 3,
  parameter int DATA_W = 32
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           wr_i,
  input  logic [ADDR_W-1:0]              addr_i,
  input  logic [DATA_W-1:0]              wdata_i,
  output logic [N_SRC-1:0]               en_o,
  output logic [N_SRC-1:0]               fast_o,
  output logic [N_PROG-1:0][SLOT_W-1:0]  slot_o,
  output logic                           promote_o
);
  localparam int N_WORDS = N_SRC / DATA_W;

  logic [N_SRC-1:0]              en_q, fast_q;
  logic [N_PROG-1:0][SLOT_W-1:0] slot_q;
  logic                          promote_q;

  for (genvar w = 0; w < N_WORDS; w++) begin : g_word
    localparam logic [ADDR_W-1:0] EN_A = A_EN + ADDR_W'(w);
    localparam logic [ADDR_W-1:0] RT_A = A_ROUTE + ADDR_W'(w);
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        en_q[w*DATA_W +: DATA_W]   <= '0;
        fast_q[w*DATA_W +: DATA_W] <= '0;
      end else if (wr_i) begin
        if (addr_i == EN_A) en_q[w*DATA_W +: DATA_W]   <= wdata_i;
        if (addr_i == RT_A) fast_q[w*DATA_W +: DATA_W] <= wdata_i;
      end
    end
  end

  for (genvar p = 0; p < N_PROG; p++) begin : g_slot
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                         slot_q[p] <= '0;
      else if (wr_i && addr_i == A_SLOT)   slot_q[p] <= wdata_i[p*SLOT_W +: SLOT_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                        promote_q <= 1'b0;
    else if (wr_i && addr_i == A_CTRL)  promote_q <= wdata_i[0];
  end

  assign en_o      = en_q;
  assign fast_o    = fast_q;
  assign slot_o    = slot_q;
  assign promote_o = promote_q;

  // R10: configuration only moves on a write
  assert_cfg_hold_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> ($stable(en_q) && $stable(fast_q) && $stable(slot_q) && $stable(promote_q)));
endmodule

// File: rtl/intc_rank.sv
module intc_rank
  import intc_pkg::*;
#(
  parameter int N_SRC  = 64,
  parameter int N_PROG = 8,
  parameter int SLOT_W = 3,
  parameter int IDX_W  = $clog2(N_SRC),
  parameter int KEY_W  = 2 + SLOT_W + IDX_W
) (
  input  logic [N_PROG-1:0][SLOT_W-1:0] slot_i,
  input  logic                          promote_i,
  output logic [N_SRC-1:0][KEY_W-1:0]   key_o
);
  localparam int UPPER = N_SRC / 2;

  // key = {tier, slot, inverted index}: inverted index breaks ties toward low numbers
  for (genvar s = 0; s < N_SRC; s++) begin : g_key
    localparam logic [IDX_W-1:0] IDX = IDX_W'(s);
    if (s < N_PROG) begin : g_prog
      assign key_o[s] = {T_PROG, slot_i[s], ~IDX};
    end else if (s < UPPER) begin : g_fixed
      assign key_o[s] = {T_FIXED, {SLOT_W{1'b0}}, ~IDX};
    end else begin : g_upper
      assign key_o[s] = {(promote_i ? T_UPPER_HI : T_UPPER_LOW), {SLOT_W{1'b0}}, ~IDX};
    end
  end
endmodule

// File: rtl/intc_arb.sv
module intc_arb #(
  parameter int N     = 64,
  parameter int KEY_W = 11
) (
  input  logic [N-1:0]            req_i,
  input  logic [N-1:0][KEY_W-1:0] key_i,
  output logic                    vld_o,
  output logic [KEY_W-1:0]        key_o
);
  localparam int NODES = 2 * N - 1;

  logic [NODES-1:0]            nv;
  logic [NODES-1:0][KEY_W-1:0] nk;

  for (genvar l = 0; l < N; l++) begin : g_leaf
    assign nv[N-1+l] = req_i[l];
    assign nk[N-1+l] = key_i[l];
  end

  for (genvar i = 0; i < N - 1; i++) begin : g_node
    logic take_r;
    assign take_r = nv[2*i+2] && (!nv[2*i+1] || (nk[2*i+2] > nk[2*i+1]));
    assign nv[i]  = nv[2*i+1] || nv[2*i+2];
    assign nk[i]  = take_r ? nk[2*i+2] : nk[2*i+1];
  end

  assign vld_o = nv[0];
  assign key_o = nk[0];

  // R4: tree's valid agrees with a flat OR of the requests
  always_comb assert_any_valid_R4: assert (vld_o == (|req_i));
endmodule

// File: rtl/prio_intc.sv
module prio_intc
  import intc_pkg::*;
#(
  parameter int N_SRC  = 64,
  parameter int N_PROG = 8,
  parameter int SLOT_W = 3,
  parameter int DATA_W = 32
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [N_SRC-1:0]   src_i,
  input  logic               reg_wr_i,
  input  logic [ADDR_W-1:0]  reg_addr_i,
  input  logic [DATA_W-1:0]  reg_wdata_i,
  output logic [DATA_W-1:0]  reg_rdata_o,
  output logic               fiq_o,
  output logic               irq_o
);
  localparam int IDX_W   = $clog2(N_SRC);
  localparam int KEY_W   = 2 + SLOT_W + IDX_W;
  localparam int N_WORDS = N_SRC / DATA_W;
  localparam int N_LINE  = 2;  // 0 = fast, 1 = normal

  logic [N_SRC-1:0]              en, fast;
  logic [N_PROG-1:0][SLOT_W-1:0] slot;
  logic                          promote;
  logic [N_SRC-1:0][KEY_W-1:0]   key;
  logic [N_LINE-1:0][N_SRC-1:0]  req;
  logic [N_LINE-1:0]             win_vld;
  logic [N_LINE-1:0][KEY_W-1:0]  win_key;
  logic [N_LINE-1:0][IDX_W-1:0]  win_idx;
  logic [N_LINE-1:0][DATA_W-1:0] win_word;

  intc_regs #(.N_SRC(N_SRC), .N_PROG(N_PROG), .SLOT_W(SLOT_W), .DATA_W(DATA_W)) u_regs (
    .clk_i, .rst_ni,
    .wr_i(reg_wr_i), .addr_i(reg_addr_i), .wdata_i(reg_wdata_i),
    .en_o(en), .fast_o(fast), .slot_o(slot), .promote_o(promote)
  );

  intc_rank #(.N_SRC(N_SRC), .N_PROG(N_PROG), .SLOT_W(SLOT_W), .IDX_W(IDX_W), .KEY_W(KEY_W)) u_rank (
    .slot_i(slot), .promote_i(promote), .key_o(key)
  );

  assign req[0] = src_i & en & fast;
  assign req[1] = src_i & en & ~fast;

  for (genvar g = 0; g < N_LINE; g++) begin : g_line
    intc_arb #(.N(N_SRC), .KEY_W(KEY_W)) u_arb (
      .req_i(req[g]), .key_i(key), .vld_o(win_vld[g]), .key_o(win_key[g])
    );
    assign win_idx[g]  = win_vld[g] ? ~win_key[g][IDX_W-1:0] : '0;
    assign win_word[g] = {win_vld[g], {(DATA_W-1-IDX_W){1'b0}}, win_idx[g]};

    // R2/R3: winner is pending, enabled and routed to this line
    always_comb assert_win_eligible_R3: assert (!win_vld[g] ||
      (src_i[win_idx[g]] && en[win_idx[g]] && (fast[win_idx[g]] == (g == 0))));
  end

  assign fiq_o = win_vld[0];
  assign irq_o = win_vld[1];

  always_comb begin
    reg_rdata_o = '0;
    for (int w = 0; w < N_WORDS; w++) begin
      if (reg_addr_i == A_EN + ADDR_W'(w))    reg_rdata_o = en[w*DATA_W +: DATA_W];
      if (reg_addr_i == A_ROUTE + ADDR_W'(w)) reg_rdata_o = fast[w*DATA_W +: DATA_W];
      if (reg_addr_i == A_RAW + ADDR_W'(w))   reg_rdata_o = src_i[w*DATA_W +: DATA_W];
    end
    if (reg_addr_i == A_SLOT) reg_rdata_o = DATA_W'(slot);
    if (reg_addr_i == A_CTRL) reg_rdata_o = DATA_W'(promote);
    if (reg_addr_i == A_FWIN) reg_rdata_o = win_word[0];
    if (reg_addr_i == A_NWIN) reg_rdata_o = win_word[1];
  end

  // R2: disabled sources never raise a line
  always_comb assert_disabled_quiet_R2: assert ((|(src_i & en)) || (!fiq_o && !irq_o));
  // R3: one source cannot win both lines
  always_comb assert_lines_disjoint_R3: assert (!(win_vld[0] && win_vld[1]) || (win_idx[0] != win_idx[1]));
  // R1: quiet straight out of reset
  assert_reset_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!fiq_o && !irq_o));
endmodule

// File: tb/prio_intc_bench.sv
module prio_intc_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [63:0] src = '0;
  logic        wr = 1'b0;
  logic [3:0]  addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        fiq, irq;

  int errors = 0, checks = 0;
  bit done = 0;

  logic [63:0] m_en = '0, m_fast = '0;
  int          m_slot[8];
  bit          m_promote = 0;

  always #10 clk = ~clk;

  prio_intc u_prio_intc (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .reg_wr_i(wr), .reg_addr_i(addr),
    .reg_wdata_i(wdata), .reg_rdata_o(rdata), .fiq_o(fiq), .irq_o(irq)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int score(int s);
    int tier, sl;
    if (s < 8)       tier = 2;
    else if (s < 32) tier = 1;
    else             tier = m_promote ? 3 : 0;
    sl = (s < 8) ? m_slot[s] : 0;
    return tier * 100000 + sl * 1000 + (63 - s);
  endfunction

  function automatic logic [31:0] model_win(bit want_fast);
    int best = -1, bs = -1;
    for (int s = 0; s < 64; s++)
      if (src[s] && m_en[s] && (m_fast[s] == want_fast) && score(s) > bs) begin
        bs = score(s); best = s;
      end
    return (best < 0) ? 32'd0 : (32'h8000_0000 | 32'(best));
  endfunction

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    addr = a; #1; d = rdata;
  endtask

  task automatic wreg(logic [3:0] a, logic [31:0] d);
    @(negedge clk); wr = 1; addr = a; wdata = d;
    @(posedge clk);
    case (a)
      4'd0: m_en[31:0]    = d;
      4'd1: m_en[63:32]   = d;
      4'd2: m_fast[31:0]  = d;
      4'd3: m_fast[63:32] = d;
      4'd4: for (int p = 0; p < 8; p++) m_slot[p] = int'(d[p*3 +: 3]);
      4'd5: m_promote = d[0];
      default: ;
    endcase
    #1 wr = 0;
  endtask

  task automatic cmp(string tag);
    logic [31:0] fw, nw, d;
    fw = model_win(1); nw = model_win(0);
    #2;
    check({tag, " R4 fiq_o"}, {31'd0, fiq}, {31'd0, fw[31]});
    check({tag, " R4 irq_o"}, {31'd0, irq}, {31'd0, nw[31]});
    rd(4'd8, d); check({tag, " R9 fast winner"}, d, fw);
    rd(4'd9, d); check({tag, " R9 normal winner"}, d, nw);
  endtask

  task automatic drive(logic [63:0] v, string tag);
    @(negedge clk); src = v; cmp(tag);
  endtask

  initial begin
    logic [31:0] d;
    for (int p = 0; p < 8; p++) m_slot[p] = 0;
    repeat (3) @(posedge clk);
    #3 rst_n = 1;
    // R1 reset state
    @(negedge clk);
    for (int a = 0; a < 10; a++) begin
      rd(4'(a), d);
      check("R1 reset readback", d, 32'd0);
    end
    src = '1; cmp("R1 reset quiet");

    // R10 readback and raw status
    wreg(4'd4, 32'h00FA_C688);
    @(negedge clk); rd(4'd4, d); check("R10 slot readback", d, 32'h00FA_C688);
    wreg(4'd5, 32'h0000_0001);
    @(negedge clk); rd(4'd5, d); check("R10 ctrl readback", d, 32'h1);
    wreg(4'd5, 32'h0);
    wreg(4'd4, 32'h0);
    wreg(4'd8, 32'hFFFF_FFFF);
    wreg(4'd6, 32'hFFFF_FFFF);
    @(negedge clk); src = 64'h1234_5678_9ABC_DEF0;
    rd(4'd6, d); check("R10 raw low", d, 32'h9ABC_DEF0);
    rd(4'd7, d); check("R10 raw high", d, 32'h1234_5678);
    rd(4'd8, d); check("R10 winner write ignored", d, 32'd0);

    // R2 disabled sources
    wreg(4'd0, 32'hFFFF_FFF7);
    wreg(4'd1, 32'hFFFF_FFFF);
    drive(64'h8, "R2 disabled src3");
    @(negedge clk); rd(4'd0, d); check("R10 enable readback", d, 32'hFFFF_FFF7);
    wreg(4'd0, 32'hFFFF_FFFF);

    // R6 ties among programmable sources
    drive(64'h28, "R6 tie 3 vs 5");
    // R5 slot value
    wreg(4'd4, 32'(7) << 15);
    drive(64'h128, "R5 slot5 high");
    drive(64'h108, "R5 src3 over src8");
    // R7 fixed ordering
    drive(64'h0000_0100_4000_0200, "R7 9 beats 30 and 40");
    drive(64'h0000_0102_0000_0000, "R7 33 beats 40");
    drive(64'h0000_0001_8000_0000, "R7 31 beats 32");
    // R8 promote
    wreg(4'd5, 32'h1);
    drive(64'h0004_0000_0000_0004, "R8 50 beats 2");
    drive(64'h0000_0000_0000_0004, "R8 lower alone");
    wreg(4'd5, 32'h0);
    drive(64'h0004_0000_0000_0004, "R8 off 2 beats 50");
    // R3 routing
    wreg(4'd2, 32'h0000_0010);
    drive(64'h0000_0000_0000_0210, "R3 fast 4 normal 9");
    wreg(4'd3, 32'h0000_0100);
    drive(64'h0000_0100_0000_0000, "R3 fast 40 only");
    @(negedge clk); rd(4'd3, d); check("R10 route readback", d, 32'h0000_0100);

    // randomised priority sweep
    for (int c = 0; c < 3000; c++) begin
      if (c % 150 == 0) begin
        wreg(4'd0, $urandom | $urandom);
        wreg(4'd1, $urandom | $urandom);
        wreg(4'd2, $urandom);
        wreg(4'd3, $urandom);
        wreg(4'd4, $urandom);
        wreg(4'd5, 32'($urandom_range(0, 1)));
      end
      if (c % 3 == 0) drive({$urandom, $urandom} & {$urandom, $urandom} & {$urandom, $urandom},
                            "R5 R6 R7 R8 sparse");
      else drive({$urandom, $urandom}, "R3 R7 dense");
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule